// File: doc/BRIEF.md
# Triplicated Self-Scrubbing Block Memory

This block is a synchronous RAM that keeps three identical copies of its contents. A single user port writes the same word into all three copies. It reads back the bitwise two-out-of-three majority of the copies, so an upset in any one copy is hidden from the user. Each copy also has a second port. That port belongs only to an internal scrubber, which walks the address space, votes each word and writes the voted value back into all three copies. An upset copy is therefore repaired, not just masked.

The scrubber is a three-state machine. `SC_IDLE` waits for `scrub_en`. `SC_FETCH` reads the current scrub address from all three copies. `SC_MEND` writes the voted word back and moves to the next address, wrapping from the last address to zero. The transitions are: `SC_IDLE -> SC_FETCH` when `scrub_en` is high. `SC_FETCH -> SC_MEND` always. `SC_MEND -> SC_FETCH` while `scrub_en` stays high. `SC_MEND -> SC_IDLE` when it drops.

Each scrub visit where the copies disagree sets a sticky flag and adds one to a saturating counter. A fault-injection input flips a single chosen bit in one chosen copy, which lets tests create upsets.

Top module: `tmr_scrub_ram`

## Requirements
- R1: Every user write stores `usr_wdata` at `usr_addr` in all three copies.
- R2: `usr_rdata` is the bitwise majority of the three copies at the address presented one clock earlier.
- R3: With scrubbing enabled, a word with one upset copy is rewritten to the voted value within one pass of 2*DEPTH cycles. The scrub address steps by one per visit and wraps from DEPTH-1 to 0.
- R4: User reads and writes are never stalled or changed by scrubbing. The scrub write-back is dropped when the user writes the scrub address in the fetch cycle or in the write-back cycle, so the user data wins.
- R5: When two copies hold the same flipped bit at one word, reads return the flipped value. Correction is not guaranteed in this case.
- R6: A scrub visit that finds disagreeing copies sets `err_seen` and increments `err_count`. The counter saturates at 2^CW-1.
- R7: `err_clr` clears `err_seen` and `err_count` on the next edge, and takes priority over a coincident increment.
- R8: After reset the scrubber is idle at address 0 and issues no writes until `scrub_en` is high. When `scrub_en` drops, the scrubber completes the current visit and returns to idle.
- R9: A cycle with `inj_en` high inverts bit `inj_bit` of copy `inj_copy` (0, 1 or 2; the value 3 selects no copy) at `inj_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| usr_addr | input | AW | User address |
| usr_we | input | 1 | User write enable |
| usr_wdata | input | DW | User write data |
| usr_rdata | output | DW | Voted read data, one-cycle latency |
| scrub_en | input | 1 | Allows the scrubber to run |
| err_clr | input | 1 | Clears the error flag and the error counter |
| inj_en | input | 1 | Fault-injection strobe |
| inj_copy | input | 2 | Copy to upset |
| inj_addr | input | AW | Address to upset |
| inj_bit | input | $clog2(DW) | Bit to invert |
| err_seen | output | 1 | Sticky disagreement flag |
| err_count | output | CW | Saturating count of disagreeing visits |

## Verification
The bench builds the block with AW=3, DW=8 and CW=3. An eight-word array keeps one scrub pass to 16 cycles, so a 40-cycle scrub window always covers a full pass. With a three-bit counter, upsetting all eight words in one pass drives the counter past its limit and reaches saturation at 7. Back-to-back user writes over the small array, made while the scrubber runs, repeatedly land on the address being scrubbed in both its fetch cycle and its write-back cycle.

// File: rtl/tmr_scrub_pkg.sv
package tmr_scrub_pkg;
    typedef enum logic [1:0] {
        SC_IDLE  = 2'd0,
        SC_FETCH = 2'd1,
        SC_MEND  = 2'd2
    } scrub_state_e;
endpackage

// File: rtl/tmr_copy.sv
module tmr_copy #(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic                  clk,
    input  logic [AW-1:0]         a_addr,
    input  logic                  a_we,
    input  logic [DW-1:0]         a_wdata,
    output logic [DW-1:0]         a_rdata,
    input  logic [AW-1:0]         b_addr,
    input  logic                  b_we,
    input  logic [DW-1:0]         b_wdata,
    output logic [DW-1:0]         b_rdata,
    input  logic                  flip,
    input  logic [AW-1:0]         flip_addr,
    input  logic [$clog2(DW)-1:0] flip_bit
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    // Read-first on both ports; the user write is placed after the scrub
    // write, so it wins on a shared word, and an upset is applied last.
    always_ff @(posedge clk) begin
        a_rdata <= cells[a_addr];
        b_rdata <= cells[b_addr];
        if (b_we)
            cells[b_addr] <= b_wdata;
        if (a_we)
            cells[a_addr] <= a_wdata;
        if (flip)
            cells[flip_addr][flip_bit] <= ~cells[flip_addr][flip_bit];
    end
endmodule

// File: rtl/tmr_scrub_fsm.sv
module tmr_scrub_fsm
    import tmr_scrub_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          usr_we,
    input  logic [AW-1:0] usr_addr,
    output logic [AW-1:0] scr_addr,
    output logic          scr_we,
    output logic          visit
);
    localparam logic [AW-1:0] LAST = AW'((1 << AW) - 1);

    scrub_state_e state_q, state_d;
    logic [AW-1:0] addr_q;
    logic          stale_q;
    logic          hit_now;

    assign hit_now = usr_we && (usr_addr == addr_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SC_IDLE:  if (run) state_d = SC_FETCH;
            SC_FETCH: state_d = SC_MEND;
            SC_MEND:  state_d = run ? SC_FETCH : SC_IDLE;
            default:  state_d = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SC_IDLE;
            addr_q  <= '0;
            stale_q <= 1'b0;
        end else begin
            state_q <= state_d;
            stale_q <= (state_q == SC_FETCH) && hit_now;
            if (state_q == SC_MEND)
                addr_q <= (addr_q == LAST) ? '0 : addr_q + 1'b1;
        end
    end

    always_comb begin
        scr_addr = addr_q;
        scr_we   = 1'b0;
        visit    = 1'b0;
        unique case (state_q)
            SC_IDLE:  ;
            SC_FETCH: ;
            SC_MEND: begin
                visit  = 1'b1;
                scr_we = !stale_q && !hit_now;
            end
            default: ;
        endcase
    end

    // R4
    user_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scr_we && usr_we) |-> (scr_addr != usr_addr));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SC_IDLE) |-> !scr_we);

    // R3
    addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (visit && scr_addr == LAST) |=> (scr_addr == '0));
endmodule

// File: rtl/tmr_err_log.sv
module tmr_err_log #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    input  logic          clr,
    output logic          seen,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] TOP = {CW{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            seen  <= 1'b0;
            count <= '0;
        end else if (hit) begin
            seen <= 1'b1;
            if (count != TOP)
                count <= count + 1'b1;
        end
    end

    // R6
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == TOP && !clr) |=> (count == TOP));

    // R7
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0 && !seen));
endmodule

// File: rtl/tmr_scrub_ram.sv
module tmr_scrub_ram #(
    parameter int AW = 4,
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-1:0]         usr_addr,
    input  logic                  usr_we,
    input  logic [DW-1:0]         usr_wdata,
    output logic [DW-1:0]         usr_rdata,
    input  logic                  scrub_en,
    input  logic                  err_clr,
    input  logic                  inj_en,
    input  logic [1:0]            inj_copy,
    input  logic [AW-1:0]         inj_addr,
    input  logic [$clog2(DW)-1:0] inj_bit,
    output logic                  err_seen,
    output logic [CW-1:0]         err_count
);
    localparam int COPIES = 3;

    logic [DW-1:0] a_q [COPIES];
    logic [DW-1:0] b_q [COPIES];
    logic [AW-1:0] scr_addr;
    logic          scr_we;
    logic          visit;
    logic [DW-1:0] scr_vote;
    logic          disagree;

    tmr_scrub_fsm #(.AW(AW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (scrub_en),
        .usr_we   (usr_we),
        .usr_addr (usr_addr),
        .scr_addr (scr_addr),
        .scr_we   (scr_we),
        .visit    (visit)
    );

    for (genvar i = 0; i < COPIES; i++) begin : g_copy
        tmr_copy #(.AW(AW), .DW(DW)) u_copy (
            .clk       (clk),
            .a_addr    (usr_addr),
            .a_we      (usr_we),
            .a_wdata   (usr_wdata),
            .a_rdata   (a_q[i]),
            .b_addr    (scr_addr),
            .b_we      (scr_we),
            .b_wdata   (scr_vote),
            .b_rdata   (b_q[i]),
            .flip      (inj_en && (inj_copy == 2'(i))),
            .flip_addr (inj_addr),
            .flip_bit  (inj_bit)
        );
    end

    assign usr_rdata = (a_q[0] & a_q[1]) | (a_q[0] & a_q[2]) | (a_q[1] & a_q[2]);
    assign scr_vote  = (b_q[0] & b_q[1]) | (b_q[0] & b_q[2]) | (b_q[1] & b_q[2]);
    assign disagree  = (b_q[0] != b_q[1]) || (b_q[0] != b_q[2]);

    tmr_err_log #(.CW(CW)) u_log (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (visit && disagree),
        .clr   (err_clr),
        .seen  (err_seen),
        .count (err_count)
    );
endmodule

// File: tb/tmr_scrub_ram_tb.sv
module tmr_scrub_ram_tb;
    localparam int  AW = 3;
    localparam int  DW = 8;
    localparam int  CW = 3;
    localparam int  DEPTH = 1 << AW;
    localparam time TCLK = 10ns;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [AW-1:0]         usr_addr = '0;
    logic                  usr_we = 1'b0;
    logic [DW-1:0]         usr_wdata = '0;
    logic [DW-1:0]         usr_rdata;
    logic                  scrub_en = 1'b0;
    logic                  err_clr = 1'b0;
    logic                  inj_en = 1'b0;
    logic [1:0]            inj_copy = 2'd3;
    logic [AW-1:0]         inj_addr = '0;
    logic [$clog2(DW)-1:0] inj_bit = '0;
    logic                  err_seen;
    logic [CW-1:0]         err_count;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(TCLK/2) clk = ~clk;

    tmr_scrub_ram #(.AW(AW), .DW(DW), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .usr_addr(usr_addr), .usr_we(usr_we),
        .usr_wdata(usr_wdata), .usr_rdata(usr_rdata), .scrub_en(scrub_en),
        .err_clr(err_clr), .inj_en(inj_en), .inj_copy(inj_copy),
        .inj_addr(inj_addr), .inj_bit(inj_bit), .err_seen(err_seen),
        .err_count(err_count)
    );

    function automatic logic [DW-1:0] pat(int a, int k);
        return DW'(a * (37 + 16 * k) + 5 + 90 * k);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [DW-1:0] d);
        @(negedge clk);
        usr_addr = AW'(a); usr_wdata = d; usr_we = 1'b1;
        @(negedge clk);
        usr_we = 1'b0;
    endtask

    task automatic rd_chk(string req, int a, logic [DW-1:0] exp);
        @(negedge clk);
        usr_addr = AW'(a); usr_we = 1'b0;
        @(negedge clk);
        chk(req, 32'(usr_rdata), 32'(exp));
    endtask

    task automatic inject(int c, int a, int b);
        @(negedge clk);
        inj_en = 1'b1; inj_copy = 2'(c); inj_addr = AW'(a); inj_bit = 3'(b);
        @(negedge clk);
        inj_en = 1'b0; inj_copy = 2'd3;
    endtask

    task automatic scrub_for(int n);
        @(negedge clk);
        scrub_en = 1'b1;
        repeat (n) @(negedge clk);
        scrub_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_log();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R8 reset count", 32'(err_count), 0);
        chk("R8 reset flag", 32'(err_seen), 0);
    endtask

    task automatic t_write_read();
        for (int a = 0; a < DEPTH; a++) wr(a, pat(a, 0));
        for (int a = 0; a < DEPTH; a++) rd_chk("R1/R2 readback", a, pat(a, 0));
    endtask

    task automatic t_mask_idle();
        inject(1, 2, 3);
        repeat (40) @(negedge clk);
        chk("R8 idle scrubber counts nothing", 32'(err_count), 0);
        rd_chk("R9/R2 single upset masked", 2, pat(2, 0));
    endtask

    task automatic t_repair();
        scrub_for(40);
        chk("R6 flag after visit", 32'(err_seen), 1);
        chk("R6 one disagreeing word", 32'(err_count), 1);
        inject(2, 2, 3);
        rd_chk("R3 copy repaired so second upset masked", 2, pat(2, 0));
        clear_log();
        chk("R7 count cleared", 32'(err_count), 0);
        chk("R7 flag cleared", 32'(err_seen), 0);
        scrub_for(40);
        chk("R3 second repair counted", 32'(err_count), 1);
        clear_log();
    endtask

    task automatic t_saturate();
        for (int a = 0; a < DEPTH; a++) inject(a % 3, a, a % DW);
        scrub_for(40);
        chk("R6 saturation", 32'(err_count), 32'((1 << CW) - 1));
        chk("R6 flag", 32'(err_seen), 1);
        for (int a = 0; a < DEPTH; a++) rd_chk("R3 all repaired", a, pat(a, 0));
        clear_log();
    endtask

    task automatic t_user_during_scrub();
        @(negedge clk);
        scrub_en = 1'b1;
        for (int k = 1; k <= 2; k++) begin
            for (int a = 0; a < DEPTH; a++) begin
                usr_addr = AW'(a); usr_wdata = pat(a, k); usr_we = 1'b1;
                @(negedge clk);
            end
            usr_we = 1'b0;
            @(negedge clk);
        end
        for (int a = DEPTH - 1; a >= 0; a--) begin
            usr_addr = AW'(a); usr_wdata = pat(a, 3); usr_we = 1'b1;
            @(negedge clk);
        end
        usr_we = 1'b0;
        repeat (20) @(negedge clk);
        for (int a = 0; a < DEPTH; a++) rd_chk("R4 user data wins under scrub", a, pat(a, 3));
        scrub_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 scrub saw no disagreement", 32'(err_count), 0);
    endtask

    task automatic t_accumulate();
        inject(0, 5, 0);
        inject(1, 5, 0);
        rd_chk("R5 double upset wins vote", 5, pat(5, 3) ^ 8'h01);
        scrub_for(40);
        rd_chk("R5 scrub keeps wrong vote", 5, pat(5, 3) ^ 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_mask_idle();
        t_repair();
        t_saturate();
        t_user_during_scrub();
        t_accumulate();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule